// File: doc/BRIEF.md
# Encoder Counter Serial Command Front End

This block is the serial control port of a quadrature-counter peripheral. A host talks to it as an SPI slave in mode 0: the clock idles low and both sides sample on the rising edge. While chip select is low, the first byte the host shifts in is an instruction. That byte names an operation and a target register. Any data bytes follow it, most significant byte first.

The block owns the two mode bytes, the 32-bit preset value and the output hold latch. It passes these to a separate counter core. It also drives three one-cycle strobes to that core: clear the count, load the preset into the count, and clear the status flags. The live count and the status flags come back as inputs.

All serial pins are oversampled by the system clock. Every register changes only when a complete byte has been received.

Top module: `spi_cmd_if`

## Requirements
- R1: Bits are taken MSB first on SCLK rising edges while `cs_ni` is low. The first byte is the instruction. Bits 7:6 are the operation: 00 clear, 01 read, 10 write, 11 load. Bits 5:3 select the register: 1 mode byte A, 2 mode byte B, 3 preset, 4 count, 5 hold latch, 6 status. Bits 2:0 are ignored.
- R2: A write to mode byte A or B stores the first data byte, which then appears on `mode0_o` or `mode1_o`. A read returns that byte. Further data bytes in the same transaction are ignored.
- R3: A preset write takes up to four bytes, MSB first. After n bytes, `preset_o` holds them right-aligned, with the upper bits zero. Bytes after the fourth are ignored. A preset read returns all four bytes.
- R4: A count read copies `count_i` into the hold latch when the instruction byte completes. It then returns that snapshot as four bytes, MSB first. A later hold-latch read returns the same snapshot.
- R5: A load on the count register pulses `count_load_o` for exactly one cycle. A load on the hold latch copies `count_i` into the latch.
- R6: A clear on the count register pulses `count_clr_o` for one cycle. A clear on the status register pulses `status_clr_o` for one cycle. A clear on mode A, mode B, preset or hold latch zeroes that register. A clear carries no data.
- R7: A status read returns `status_i` as one byte.
- R8: If `cs_ni` rises before a byte is complete, that byte has no effect: no register changes and no strobe is issued.
- R9: `miso_oe_o` is high only while chip select is asserted. `miso_o` is low while chip select is deasserted and during any transaction that is not a read.
- R10: Register selects 0 and 7 read as zero. Writes, clears and loads aimed at them change nothing and issue no strobe.
- R11: After reset, all held registers are zero, all strobes are low and the MISO enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idle low |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for the MISO pad |
| count_i | input | CNT_BYTES*8 | Live count from the counter core |
| status_i | input | 8 | Status flags from the counter core |
| mode0_o | output | 8 | Mode byte A |
| mode1_o | output | 8 | Mode byte B |
| preset_o | output | CNT_BYTES*8 | Preset value |
| count_clr_o | output | 1 | One-cycle strobe: zero the count |
| count_load_o | output | 1 | One-cycle strobe: load the preset into the count |
| status_clr_o | output | 1 | One-cycle strobe: zero the status flags |

## Verification
The bench goes after short and long preset writes. A design that cleared or shifted the preset in the wrong place would show stale upper bytes, or would keep a fifth byte. It also checks that a count read stays stable when `count_i` moves afterwards, which catches a read served from the live input instead of the snapshot. It aborts transactions in the middle of a byte, which exposes logic that commits bits too early. Finally it aims instructions at selects 0 and 7 and sets the reserved low bits, so a decoder that uses too many bits, or treats the spare selects as aliases, would produce stray strobes or corrupt a mode byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {
    OP_CLR = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_LD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    SEL_NONE_LO = 3'd0,
    SEL_MODE_A  = 3'd1,
    SEL_MODE_B  = 3'd2,
    SEL_PRESET  = 3'd3,
    SEL_COUNT   = 3'd4,
    SEL_HOLD    = 3'd5,
    SEL_STAT    = 3'd6,
    SEL_NONE_HI = 3'd7
  } sel_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int unsigned       STAGES  = 2,
  parameter int unsigned       N       = 3,
  parameter logic [N-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[i]}};
      else         chain_q <= {chain_q[STAGES-2:0], async_i[i]};
    end
    assign lvl_o[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         sclk_rise_i,
  input  logic         mosi_i,
  input  logic         load_i,
  input  logic [W-1:0] load_word_i,
  output logic         byte_done_o,
  output logic [7:0]   byte_o,
  output logic         miso_o
);
  logic [2:0]   bit_cnt_q;
  logic [6:0]   rx_q;
  logic [W-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
    end else if (!active_i) begin
      bit_cnt_q <= '0;
    end else if (sclk_rise_i) begin
      bit_cnt_q <= bit_cnt_q + 3'd1;
      rx_q      <= {rx_q[5:0], mosi_i};
    end
  end

  // load wins over shift on the edge that completes the instruction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           tx_q <= '0;
    else if (!active_i)    tx_q <= '0;
    else if (load_i)       tx_q <= load_word_i;
    else if (sclk_rise_i)  tx_q <= {tx_q[W-2:0], 1'b0};
  end

  assign byte_done_o = active_i & sclk_rise_i & (bit_cnt_q == 3'd7);
  assign byte_o      = {rx_q, mosi_i};
  assign miso_o      = active_i & tx_q[W-1];
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int unsigned BYTES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,
  input  logic                 byte_done_i,
  input  logic [7:0]           byte_i,
  input  logic [BYTES*8-1:0]   count_i,
  input  logic [7:0]           status_i,
  output logic [7:0]           mode0_o,
  output logic [7:0]           mode1_o,
  output logic [BYTES*8-1:0]   preset_o,
  output logic                 count_clr_o,
  output logic                 count_load_o,
  output logic                 status_clr_o,
  output logic                 load_o,
  output logic [BYTES*8-1:0]   load_word_o
);
  localparam int unsigned W     = BYTES * 8;
  localparam int unsigned IDX_W = $clog2(BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(BYTES);

  logic             in_data_q;
  op_e              op_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     stage_q;
  logic [W-1:0]     hold_q;
  sel_e             sel_q;
  op_e              op_d;
  sel_e             sel_d;
  logic             instr_done;
  logic             data_done;
  logic [W-1:0]     stage_d;

  assign op_d       = op_e'(byte_i[7:6]);
  assign sel_d      = sel_e'(byte_i[5:3]);
  assign instr_done = byte_done_i & ~in_data_q;
  assign data_done  = byte_done_i & in_data_q;
  assign stage_d    = {stage_q[W-9:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data_q <= 1'b0;
      op_q      <= OP_CLR;
      sel_q     <= SEL_NONE_LO;
      idx_q     <= '0;
    end else if (!active_i) begin
      in_data_q <= 1'b0;
      idx_q     <= '0;
    end else if (instr_done) begin
      in_data_q <= 1'b1;
      op_q      <= op_d;
      sel_q     <= sel_d;
      idx_q     <= '0;
    end else if (data_done && idx_q != IDX_MAX) begin
      idx_q     <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode0_o      <= '0;
      mode1_o      <= '0;
      preset_o     <= '0;
      stage_q      <= '0;
      hold_q       <= '0;
      count_clr_o  <= 1'b0;
      count_load_o <= 1'b0;
      status_clr_o <= 1'b0;
    end else begin
      count_clr_o  <= 1'b0;
      count_load_o <= 1'b0;
      status_clr_o <= 1'b0;
      if (instr_done) begin
        stage_q <= '0;
        unique case (op_d)
          OP_CLR: begin
            case (sel_d)
              SEL_MODE_A: mode0_o      <= '0;
              SEL_MODE_B: mode1_o      <= '0;
              SEL_PRESET: preset_o     <= '0;
              SEL_COUNT:  count_clr_o  <= 1'b1;
              SEL_HOLD:   hold_q       <= '0;
              SEL_STAT:   status_clr_o <= 1'b1;
              default: ;
            endcase
          end
          OP_RD: if (sel_d == SEL_COUNT) hold_q <= count_i;
          OP_LD: begin
            if (sel_d == SEL_COUNT) count_load_o <= 1'b1;
            if (sel_d == SEL_HOLD)  hold_q       <= count_i;
          end
          default: ;
        endcase
      end else if (data_done && op_q == OP_WR && idx_q != IDX_MAX) begin
        case (sel_q)
          SEL_MODE_A: if (idx_q == '0) mode0_o <= byte_i;
          SEL_MODE_B: if (idx_q == '0) mode1_o <= byte_i;
          SEL_PRESET: begin
            stage_q  <= stage_d;
            preset_o <= stage_d;
          end
          default: ;
        endcase
      end
    end
  end

  // read word, left aligned; count reads bypass to the value being latched
  always_comb begin
    load_o      = instr_done & (op_d == OP_RD);
    load_word_o = '0;
    case (sel_d)
      SEL_MODE_A: load_word_o = {mode0_o, {(W-8){1'b0}}};
      SEL_MODE_B: load_word_o = {mode1_o, {(W-8){1'b0}}};
      SEL_PRESET: load_word_o = preset_o;
      SEL_COUNT:  load_word_o = count_i;
      SEL_HOLD:   load_word_o = hold_q;
      SEL_STAT:   load_word_o = {status_i, {(W-8){1'b0}}};
      default:    load_word_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if #(
  parameter int unsigned CNT_BYTES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   cs_ni,
  input  logic                   mosi_i,
  output logic                   miso_o,
  output logic                   miso_oe_o,
  input  logic [CNT_BYTES*8-1:0] count_i,
  input  logic [7:0]             status_i,
  output logic [7:0]             mode0_o,
  output logic [7:0]             mode1_o,
  output logic [CNT_BYTES*8-1:0] preset_o,
  output logic                   count_clr_o,
  output logic                   count_load_o,
  output logic                   status_clr_o
);
  localparam int unsigned CNT_W = CNT_BYTES * 8;

  logic [2:0]       pins_s;
  logic             sclk_q;
  logic             active;
  logic             sclk_rise;
  logic             byte_done;
  logic [7:0]       rx_byte;
  logic             tx_load;
  logic [CNT_W-1:0] tx_word;

  spi_cmd_sync #(
    .STAGES (SYNC_STAGES),
    .N      (3),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({mosi_i, sclk_i, cs_ni}),
    .lvl_o  (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= pins_s[1];
  end

  assign active    = ~pins_s[0];
  assign sclk_rise = pins_s[1] & ~sclk_q;
  assign miso_oe_o = active;

  spi_cmd_shift #(.W(CNT_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .sclk_rise_i(sclk_rise),
    .mosi_i     (pins_s[2]),
    .load_i     (tx_load),
    .load_word_i(tx_word),
    .byte_done_o(byte_done),
    .byte_o     (rx_byte),
    .miso_o     (miso_o)
  );

  spi_cmd_regs #(.BYTES(CNT_BYTES)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .byte_done_i (byte_done),
    .byte_i      (rx_byte),
    .count_i     (count_i),
    .status_i    (status_i),
    .mode0_o     (mode0_o),
    .mode1_o     (mode1_o),
    .preset_o    (preset_o),
    .count_clr_o (count_clr_o),
    .count_load_o(count_load_o),
    .status_clr_o(status_clr_o),
    .load_o      (tx_load),
    .load_word_o (tx_word)
  );
endmodule

// File: rtl/spi_cmd_if_chk.sv
module spi_cmd_if_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cs_active,
  input logic         byte_done,
  input logic         miso_o,
  input logic         miso_oe_o,
  input logic [7:0]   mode0_o,
  input logic [W-1:0] preset_o,
  input logic         count_clr_o,
  input logic         count_load_o,
  input logic         status_clr_o
);
  assert_idle_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_active |-> (!miso_oe_o && !miso_o));

  assert_byte_framed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done |-> cs_active);

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({count_clr_o, count_load_o, status_clr_o}));

  assert_clr_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_clr_o |=> !count_clr_o);

  assert_stat_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_clr_o |=> !status_clr_o);

  assert_load_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_load_o |=> !count_load_o);

  assert_strobe_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_clr_o || count_load_o || status_clr_o) |-> $past(byte_done));

  assert_mode_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode0_o) |-> $past(byte_done));

  assert_preset_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(preset_o) |-> $past(byte_done));
endmodule

bind spi_cmd_if spi_cmd_if_chk #(.W(CNT_BYTES * 8)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_active   (active),
  .byte_done   (byte_done),
  .miso_o      (miso_o),
  .miso_oe_o   (miso_oe_o),
  .mode0_o     (mode0_o),
  .preset_o    (preset_o),
  .count_clr_o (count_clr_o),
  .count_load_o(count_load_o),
  .status_clr_o(status_clr_o)
);

// File: tb/sim_spi_cmd_if.sv
`timescale 1ns/1ps
module sim_spi_cmd_if;
  localparam int H = 6;

  typedef struct packed {
    logic [7:0]  wi;
    logic [39:0] wd;
    logic [2:0]  nw;
    logic [7:0]  ri;
    logic [2:0]  nr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'h88, 40'hA5,         3'd1, 8'h48, 3'd1, 32'hA5,       4'd2},  // R2
    '{8'h95, 40'h3C,         3'd1, 8'h50, 3'd1, 32'h3C,       4'd1},  // R1 low bits ignored
    '{8'h98, 40'h12345678,   3'd4, 8'h58, 3'd4, 32'h12345678, 4'd3},  // R3
    '{8'h98, 40'hABCD,       3'd2, 8'h58, 3'd4, 32'h0000ABCD, 4'd3},  // R3 short
    '{8'h88, 40'h5A77,       3'd2, 8'h48, 3'd1, 32'h5A,       4'd2},  // R2 extra byte
    '{8'h80, 40'hFF,         3'd1, 8'h40, 3'd1, 32'h0,        4'd10}, // R10 select 0
    '{8'hB8, 40'hFF,         3'd1, 8'h48, 3'd1, 32'h5A,       4'd10}, // R10 select 7
    '{8'h98, 40'h1122334455, 3'd5, 8'h58, 3'd4, 32'h11223344, 4'd3},  // R3 fifth byte
    '{8'hB8, 40'h0,          3'd0, 8'h78, 3'd1, 32'h0,        4'd10}, // R10 read 7
    '{8'h08, 40'h0,          3'd0, 8'h48, 3'd1, 32'h0,        4'd6},  // R6 clear mode A
    '{8'h18, 40'h0,          3'd0, 8'h58, 3'd4, 32'h0,        4'd6}   // R6 clear preset
  };

  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic [31:0] count = '0;
  logic [7:0]  status = '0;
  logic miso, miso_oe, clr_s, load_s, sclr_s;
  logic [7:0] mode0, mode1;
  logic [31:0] preset;
  int checks = 0, errors = 0;
  int n_clr = 0, n_load = 0, n_sclr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_cmd_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .count_i(count), .status_i(status),
    .mode0_o(mode0), .mode1_o(mode1), .preset_o(preset),
    .count_clr_o(clr_s), .count_load_o(load_s), .status_clr_o(sclr_s)
  );

  always @(posedge clk) begin
    if (clr_s)  n_clr++;
    if (load_s) n_load++;
    if (sclr_s) n_sclr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic r);
    sclk = 0; mosi = b;
    wait_n(H);
    r = miso;
    sclk = 1;
    wait_n(H);
  endtask

  task automatic spi_txn(input logic [7:0] ins, input logic [39:0] wd, input int nw,
                         input int nr, output logic [31:0] rd);
    logic r;
    int nb;
    logic [7:0] b;
    nb = (nw > nr) ? nw : nr;
    rd = '0;
    @(negedge clk); cs_n = 0; wait_n(H);
    for (int i = 7; i >= 0; i--) send_bit(ins[i], r);
    for (int k = 0; k < nb; k++) begin
      b = (k < nw) ? wd[8*(nw-1-k) +: 8] : 8'h00;
      for (int i = 7; i >= 0; i--) begin
        send_bit(b[i], r);
        rd = {rd[30:0], r};
      end
    end
    sclk = 0; wait_n(H);
    cs_n = 1; wait_n(2*H);
  endtask

  task automatic spi_cut(input logic [15:0] v, input int n);
    logic r;
    @(negedge clk); cs_n = 0; wait_n(H);
    for (int i = 15; i > 15 - n; i--) send_bit(v[i], r);
    sclk = 0; wait_n(H);
    cs_n = 1; wait_n(2*H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int c0, l0, s0;
    wait_n(5);
    chk("R11 mode0", {24'h0, mode0}, 32'h0);
    chk("R11 mode1", {24'h0, mode1}, 32'h0);
    chk("R11 preset", preset, 32'h0);
    chk("R11 oe/strobes", {28'h0, miso_oe, clr_s, load_s, sclr_s}, 32'h0);
    rst_n = 1;
    wait_n(5);

    for (int v = 0; v < NV; v++) begin
      spi_txn(VEC[v].wi, VEC[v].wd, int'(VEC[v].nw), 0, rd);
      spi_txn(VEC[v].ri, 40'h0, 0, int'(VEC[v].nr), rd);
      chk($sformatf("R%0d vector %0d", VEC[v].req, v), rd, VEC[v].exp);
    end

    // R2 / R3 at the ports, and R9 quiet MISO on a write
    spi_txn(8'h90, 40'h3C, 1, 0, rd);
    chk("R2 mode1 port", {24'h0, mode1}, 32'h3C);
    spi_txn(8'h98, 40'hCAFE01, 3, 0, rd);
    chk("R3 preset port", preset, 32'h00CAFE01);
    spi_txn(8'h88, 40'h66, 1, 0, rd);
    chk("R9 miso low on write", rd, 32'h0);
    chk("R2 mode0 port", {24'h0, mode0}, 32'h66);

    // R4 snapshot
    count = 32'hDEADBEEF;
    spi_txn(8'h60, 40'h0, 0, 4, rd);
    chk("R4 count read", rd, 32'hDEADBEEF);
    count = 32'h01020304;
    spi_txn(8'h68, 40'h0, 0, 4, rd);
    chk("R4 hold keeps snapshot", rd, 32'hDEADBEEF);

    // R5 loads
    count = 32'h0BADF00D;
    spi_txn(8'hE8, 40'h0, 0, 0, rd);
    spi_txn(8'h68, 40'h0, 0, 4, rd);
    chk("R5 load hold", rd, 32'h0BADF00D);
    c0 = n_clr; l0 = n_load; s0 = n_sclr;
    spi_txn(8'hE0, 40'h0, 0, 0, rd);
    chk("R5 load strobe one cycle", n_load - l0, 1);
    chk("R5 no other strobe", (n_clr - c0) + (n_sclr - s0), 0);

    // R6 clears
    c0 = n_clr; s0 = n_sclr;
    spi_txn(8'h20, 40'h0, 0, 0, rd);
    chk("R6 count clear strobe", n_clr - c0, 1);
    spi_txn(8'h30, 40'h0, 0, 0, rd);
    chk("R6 status clear strobe", n_sclr - s0, 1);
    spi_txn(8'h28, 40'h0, 0, 0, rd);
    spi_txn(8'h68, 40'h0, 0, 4, rd);
    chk("R6 hold cleared", rd, 32'h0);

    // R7 status
    status = 8'hC3;
    spi_txn(8'h70, 40'h0, 0, 1, rd);
    chk("R7 status read", rd, 32'hC3);

    // R10 spare selects issue no strobe
    c0 = n_clr; l0 = n_load; s0 = n_sclr;
    spi_txn(8'h00, 40'h0, 0, 0, rd);
    spi_txn(8'hC0, 40'h0, 0, 0, rd);
    spi_txn(8'h38, 40'h0, 0, 0, rd);
    spi_txn(8'hF8, 40'h0, 0, 0, rd);
    chk("R10 no strobes", (n_clr - c0) + (n_load - l0) + (n_sclr - s0), 0);

    // R8 aborts
    spi_cut({8'h88, 8'h11}, 13);
    chk("R8 mode0 kept", {24'h0, mode0}, 32'h66);
    c0 = n_clr;
    spi_cut({8'h20, 8'h00}, 6);
    chk("R8 no clear strobe", n_clr - c0, 0);
    spi_txn(8'h48, 40'h0, 0, 1, rd);
    chk("R8 framing recovers", rd, 32'h66);

    // R9 enable follows chip select
    @(negedge clk); cs_n = 0; wait_n(H);
    chk("R9 oe while selected", {31'h0, miso_oe}, 32'h1);
    cs_n = 1; wait_n(H);
    chk("R9 idle line", {30'h0, miso_oe, miso}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule